// File: doc/BRIEF.md
# Multiplexed-Address ROM with Chained Select

This block is a synchronous model of a 1024-word by 8-bit read-only memory that sits on an 8-bit multiplexed address bus. A processor places the upper byte of a 16-bit address on the bus and pulses a high-address strobe, and the block captures that byte in a register. During the read that follows, the same bus carries the lower byte, and the block uses it directly without latching it. The upper six captured bits pick one 1K block of the 64K space. That block is a build-time parameter, so the device answers in that block and nowhere else.

Two chip-select inputs gate the data bus, and so does an active-low read strobe. The active level of each select, of the high-address strobe and of the chain input is a build-time parameter. The data bus is three-state: it is driven only during a qualified read. A chain input and a chain output let several devices be wired in series. The chain output goes high whenever this device's block matches the captured address, and also whenever an upstream device reports a claim. Memory further down the chain reads a high chain output as "address taken" and stays off the bus. The memory image is a parameter, and by default it is computed from a formula.

Top module: `mux_rom_chain`

## Requirements
- R1: When reset is asserted, the captured high byte is cleared to 0x00. Because the default block is 1, a reset device then reports no block match, keeps its bus released, and drives the chain output low while the chain input is inactive.
- R2: On a rising clock edge at which the high-address strobe is at its active level (active-high by default), the upper-byte register loads the bus value. At every other edge it keeps its value.
- R3: The block matches when captured bits [7:2] equal the 6-bit block parameter. With the default block of 1, this means captured high bytes 0x04 to 0x07, which is addresses 0x0400 to 0x07FF.
- R4: During a qualified read, the data bus carries the image word at index {captured bits [1:0], live bus byte}. The default image word at index i is ((i*29) XOR (i>>2)) mod 256.
- R5: The data-bus enable output, and the drive on the bus, are active only when four things hold together: the block matches, select A is active, select B is active, and the read strobe is low.
- R6: The active levels of the selects are parameters. By default select A is active-high and select B is active-low, and an inactive select releases the bus.
- R7: The chain output is high when the block matches or when the chain input is at its active level (active-high by default). An inactive chain input does not suppress a local match.
- R8: The chain output does not depend on the selects or on the read strobe.
- R9: Changing the bus byte while the strobe is inactive changes the word index through the low byte only. The captured high byte, and therefore the match, stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Multiplexed address bus (high byte at the strobe, low byte during the read) |
| hi_stb_i | input | 1 | High-address strobe, polarity set by parameter |
| chain_in_i | input | 1 | Upstream claim input, polarity set by parameter |
| sel_a_i | input | 1 | Chip select A, polarity set by parameter |
| sel_b_i | input | 1 | Chip select B, polarity set by parameter |
| rd_ni | input | 1 | Memory read strobe, active low |
| data_io | inout | 8 | Three-state data bus |
| data_oe_o | output | 1 | High while the block drives data_io |
| chain_out_o | output | 1 | Claim output to downstream memory, active high |

## Verification
The bench sweeps captured high bytes on both sides of the 0x03/0x04 and 0x07/0x08 edges, each with low bytes 0x00 and 0xFF. An off-by-one decode would therefore either claim a neighbouring block or lose one end of its own. It changes the bus byte between strobes to catch a capture register that is transparent instead of edge-loaded, which would show up as a wrong word or a false match. Random vectors then toggle each select, the read strobe and the chain input independently. These expose a swapped select polarity, a chain output that drops when the selects are inactive, and a chain input that masks the local decode.

// File: rtl/mrom_pkg.sv
package mrom_pkg;
  localparam int unsigned BusW   = 8;
  localparam int unsigned DataW  = 8;
  localparam int unsigned IdxW   = 10;
  localparam int unsigned Words  = 1 << IdxW;
  localparam int unsigned TagW   = 16 - IdxW;

  typedef logic [BusW-1:0]  bus_t;
  typedef logic [DataW-1:0] word_t;
  typedef logic [IdxW-1:0]  idx_t;

  function automatic logic [Words*DataW-1:0] default_image();
    logic [Words*DataW-1:0] img;
    img = '0;
    for (int i = 0; i < Words; i++) begin
      img[i*DataW +: DataW] = DataW'((i * 29) ^ (i >> 2));
    end
    return img;
  endfunction
endpackage

// File: rtl/mrom_pol.sv
module mrom_pol #(
  parameter bit ACT_HIGH = 1'b1
) (
  input  logic raw_i,
  output logic act_o
);
  if (ACT_HIGH) begin : g_high
    assign act_o = raw_i;
  end else begin : g_low
    assign act_o = ~raw_i;
  end
endmodule

// File: rtl/mrom_hi_latch.sv
module mrom_hi_latch
  import mrom_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  bus_t bus_i,
  output bus_t hi_o
);
  bus_t hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_q <= '0;
    else if (stb_i) hi_q <= bus_i;
  end

  assign hi_o = hi_q;
endmodule

// File: rtl/mrom_decode.sv
module mrom_decode
  import mrom_pkg::*;
#(
  parameter int unsigned BASE_BLOCK = 1
) (
  input  bus_t hi_i,
  input  bus_t lo_i,
  output logic hit_o,
  output idx_t idx_o
);
  localparam int unsigned HiIdxW = IdxW - BusW;
  localparam logic [TagW-1:0] BaseTag = TagW'(BASE_BLOCK);

  assign hit_o = (hi_i[BusW-1:HiIdxW] == BaseTag);
  assign idx_o = {hi_i[HiIdxW-1:0], lo_i};
endmodule

// File: rtl/mrom_array.sv
module mrom_array
  import mrom_pkg::*;
#(
  parameter logic [Words*DataW-1:0] IMAGE = default_image()
) (
  input  idx_t  idx_i,
  output word_t word_o
);
  assign word_o = IMAGE[idx_i*DataW +: DataW];
endmodule

// File: rtl/mux_rom_chain.sv
module mux_rom_chain
  import mrom_pkg::*;
#(
  parameter int unsigned BASE_BLOCK   = 1,
  parameter bit STB_ACT_HIGH          = 1'b1,
  parameter bit CHAIN_ACT_HIGH        = 1'b1,
  parameter bit SEL_A_ACT_HIGH        = 1'b1,
  parameter bit SEL_B_ACT_HIGH        = 1'b0,
  parameter logic [Words*DataW-1:0] IMAGE = default_image()
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BusW-1:0]  addr_i,
  input  logic             hi_stb_i,
  input  logic             chain_in_i,
  input  logic             sel_a_i,
  input  logic             sel_b_i,
  input  logic             rd_ni,
  inout  wire  [DataW-1:0] data_io,
  output logic             data_oe_o,
  output logic             chain_out_o
);
  logic  stb_act, chain_act, sel_a_act, sel_b_act;
  bus_t  hi_q;
  logic  blk_hit;
  idx_t  word_idx;
  word_t rd_word;

  mrom_pol #(.ACT_HIGH(STB_ACT_HIGH))   u_pol_stb (.raw_i(hi_stb_i),   .act_o(stb_act));
  mrom_pol #(.ACT_HIGH(CHAIN_ACT_HIGH)) u_pol_chn (.raw_i(chain_in_i), .act_o(chain_act));
  mrom_pol #(.ACT_HIGH(SEL_A_ACT_HIGH)) u_pol_sa  (.raw_i(sel_a_i),    .act_o(sel_a_act));
  mrom_pol #(.ACT_HIGH(SEL_B_ACT_HIGH)) u_pol_sb  (.raw_i(sel_b_i),    .act_o(sel_b_act));

  mrom_hi_latch u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stb_i (stb_act),
    .bus_i (addr_i),
    .hi_o  (hi_q)
  );

  mrom_decode #(.BASE_BLOCK(BASE_BLOCK)) u_dec (
    .hi_i (hi_q),
    .lo_i (addr_i),
    .hit_o(blk_hit),
    .idx_o(word_idx)
  );

  mrom_array #(.IMAGE(IMAGE)) u_arr (
    .idx_i (word_idx),
    .word_o(rd_word)
  );

  // chain output ignores selects and read strobe
  assign chain_out_o = blk_hit | chain_act;
  assign data_oe_o   = blk_hit & sel_a_act & sel_b_act & ~rd_ni;
  assign data_io     = data_oe_o ? rd_word : 'z;
endmodule

// File: rtl/mux_rom_chain_chk.sv
module mux_rom_chain_chk
  import mrom_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic [BusW-1:0] addr_i,
  input logic rd_ni,
  input logic stb_act,
  input logic sel_a_act,
  input logic sel_b_act,
  input logic chain_act,
  input logic blk_hit,
  input bus_t hi_q,
  input logic data_oe_o,
  input logic chain_out_o
);
  a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_act |=> hi_q == $past(addr_i));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_act |=> $stable(hi_q));
  a_r5_oe_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !rd_ni);
  a_r5_oe_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> blk_hit);
  a_r6_oe_needs_sels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (sel_a_act && sel_b_act));
  a_r7_hit_claims: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_hit |-> chain_out_o);
  a_r7_pass_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_act |-> chain_out_o);
endmodule

bind mux_rom_chain mux_rom_chain_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .rd_ni      (rd_ni),
  .stb_act    (stb_act),
  .sel_a_act  (sel_a_act),
  .sel_b_act  (sel_b_act),
  .chain_act  (chain_act),
  .blk_hit    (blk_hit),
  .hi_q       (hi_q),
  .data_oe_o  (data_oe_o),
  .chain_out_o(chain_out_o)
);

// File: tb/mux_rom_chain_tb_top.sv
module mux_rom_chain_tb_top;
  localparam int unsigned BASE = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic stb = 1'b0, cin = 1'b0, sa = 1'b1, sb = 1'b0, rd_n = 1'b1;
  wire  [7:0] data_bus;
  logic oe, cout;

  int nvec = 0, nfail = 0;
  logic [7:0] exp_hi = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mux_rom_chain dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .hi_stb_i(stb),
    .chain_in_i(cin), .sel_a_i(sa), .sel_b_i(sb), .rd_ni(rd_n),
    .data_io(data_bus), .data_oe_o(oe), .chain_out_o(cout)
  );

  function automatic logic [7:0] img(input int unsigned i);
    return 8'((i * 29) ^ (i >> 2));
  endfunction

  function automatic bit hit(input logic [7:0] h);
    return h[7:2] == 6'(BASE);
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [7:0] lo);
    bit e_hit, e_oe;
    e_hit = hit(exp_hi);
    e_oe  = e_hit && sa && !sb && !rd_n;
    chk({req, " oe"}, {7'd0, oe}, {7'd0, e_oe});
    chk({req, " chain"}, {7'd0, cout}, {7'd0, e_hit | cin});
    if (e_oe) chk({req, " data"}, data_bus, img({exp_hi[1:0], lo}));
  endtask

  task automatic apply(input string req, input logic [7:0] h, input logic [7:0] lo,
                       input logic a, input logic b, input logic r, input logic c);
    @(negedge clk);
    addr = h; stb = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    exp_hi = h;
    stb = 1'b0; addr = lo; sa = a; sb = b; rd_n = r; cin = c;
    #1 check_out(req, lo);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    logic [7:0] hb [8];
    seed_v = $urandom(32'h5eed_1833);
    hb = '{8'h00, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'hff};
    // R1: reset state with a fully qualified read attempt
    addr = 8'h10; sa = 1'b1; sb = 1'b0; rd_n = 1'b0; cin = 1'b0;
    repeat (3) @(negedge clk);
    check_out("R1 in reset", 8'h10);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1 after reset", 8'h10);
    // R3 boundary sweep, R4 data
    foreach (hb[k]) begin
      apply("R3 sweep lo00", hb[k], 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
      apply("R3 sweep loff", hb[k], 8'hff, 1'b1, 1'b0, 1'b0, 1'b0);
    end
    // R8: chain output with selects and read inactive
    apply("R8 hit no sel", 8'h05, 8'h33, 1'b0, 1'b1, 1'b1, 1'b0);
    apply("R8 miss no sel", 8'h09, 8'h33, 1'b0, 1'b1, 1'b1, 1'b0);
    // R7: chain input passes, does not mask local match
    apply("R7 claim in miss", 8'h20, 8'h01, 1'b1, 1'b0, 1'b0, 1'b1);
    apply("R7 claim in hit", 8'h04, 8'h01, 1'b1, 1'b0, 1'b0, 1'b1);
    // R6: each select inactive alone
    apply("R6 sel_a off", 8'h06, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0);
    apply("R6 sel_b off", 8'h06, 8'h80, 1'b1, 1'b1, 1'b0, 1'b0);
    apply("R5 rd high", 8'h06, 8'h80, 1'b1, 1'b0, 1'b1, 1'b0);
    // R2/R9: bus changes without strobe keep the captured byte
    apply("R2 base", 8'h07, 8'h12, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int j = 0; j < 4; j++) begin
      logic [7:0] lo;
      @(negedge clk);
      lo = (j == 0) ? 8'h00 : 8'($urandom());
      addr = lo;
      #1 check_out("R9 live low byte R2 hold", lo);
    end
    apply("R2 move out", 8'h08, 8'h12, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    addr = 8'h05;
    #1 check_out("R2 hold miss", 8'h05);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] h;
      h = ($urandom() % 3 == 0) ? 8'($urandom()) : 8'(8'h02 + $urandom() % 8);
      apply("R5 random", h, 8'($urandom()), 1'($urandom()), 1'($urandom()),
            1'($urandom()), 1'($urandom()));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule